// File: doc/BRIEF.md
# Store-Load Overlap Detector

This block keeps a small table of the stores issued in the current dispatch group. Each load is checked against that table, and an overlap flag is raised in the same cycle when the load may touch bytes a recorded store writes. Each access is described by three values: a base identifier naming the pointer it is relative to, a signed byte offset from that base, and a byte count. Only accesses that share a base are compared. Accesses on different bases are treated as independent.

The surrounding scheduler presents each store with a flag that says whether its size is known. Only stores with a known size take a table slot. When the table is full, further stores are dropped without notice. A clear input empties the table at the end of each group. What the scheduler does with a hit is outside this block.

Top module: `stld_alias_table`

## Requirements
- R1: After reset the table is empty, and `ld_hit` is 0 for every load.
- R2: A store with `st_valid`=1 and `st_size_ok`=1 is written into the table at the rising clock edge. A later load with the same base and the same offset then gives `ld_hit`=1, whatever the two sizes are (including zero).
- R3: When the bases match and the store offset is lower than the load offset (signed compare), `ld_hit`=1 exactly when store offset + store size > load offset.
- R4: When the bases match and the store offset is equal to or higher than the load offset, `ld_hit`=1 exactly when load offset + load size > store offset.
- R5: A load whose base differs from the base of every recorded store gives `ld_hit`=0.
- R6: A store presented with `st_size_ok`=0 is not recorded. A matching load afterwards gives `ld_hit`=0.
- R7: The table holds at most DEPTH stores (4 by default). Stores after the table is full are dropped, and the entries already held stay unchanged.
- R8: `grp_clr`=1 at a clock edge empties the table. A store presented at the same edge is discarded.
- R9: `ld_hit` is combinational and is 0 whenever `ld_valid`=0. A load sees only stores recorded at earlier edges, never the store presented in the same cycle.
- R10: Offsets are signed two's-complement values and sizes are unsigned. Sums are formed one bit wider than the offset, so a range that ends past the largest positive offset does not wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grp_clr | input | 1 | Empty the table at this edge (end of group) |
| st_valid | input | 1 | A store is presented this cycle |
| st_size_ok | input | 1 | The presented store has a known size |
| st_base | input | BASE_W | Store base identifier |
| st_off | input | OFF_W | Store signed byte offset |
| st_size | input | SIZE_W | Store size in bytes |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_base | input | BASE_W | Load base identifier |
| ld_off | input | OFF_W | Load signed byte offset |
| ld_size | input | SIZE_W | Load size in bytes |
| ld_hit | output | 1 | The load overlaps a recorded store |

## Verification
The bench builds the block with its default parameters: four entries, 8-bit bases, 16-bit signed offsets, 8-bit sizes and the ordered compare variant. These values let the bench reach the end of the offset range, where a 16-bit sum would wrap and miss a real overlap. They also let a fifth store arrive at a full table. Both compare branches are driven on either side of their strict inequality. Zero-size exact matches, negative offsets and a clear that coincides with a store are each exercised.

// File: rtl/stld_alias_pkg.sv
package stld_alias_pkg;

   // Variants of the per-entry overlap comparison; both give the same result.
   typedef enum int {
      CMP_ORDERED = 0,   // branch on which offset is lower, test one end
      CMP_SPAN    = 1    // test both interval ends in parallel
   } cmp_style_e;

endpackage

// File: rtl/stld_fill.sv
module stld_fill #(
   parameter int DEPTH = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   output logic [CNT_W-1:0] cnt,
   output logic [DEPTH-1:0] wr_en,
   output logic [DEPTH-1:0] live
);

   logic room;
   assign room = (cnt < CNT_W'(DEPTH));

   for (genvar i = 0; i < DEPTH; i++) begin : g_sel
      assign wr_en[i] = push && !clr && (cnt == CNT_W'(i));
      assign live[i]  = (cnt > CNT_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (push && room)
         cnt <= cnt + CNT_W'(1);
   end

   // R7
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

   // R7
   one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en));

   // R7
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(DEPTH)) && !clr |=> (cnt == CNT_W'(DEPTH)));

   // R8
   clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (live == '0));

endmodule

// File: rtl/stld_slot.sv
module stld_slot
   import stld_alias_pkg::*;
#(
   parameter int         BASE_W    = 8,
   parameter int         OFF_W     = 16,
   parameter int         SIZE_W    = 8,
   parameter cmp_style_e CMP_STYLE = CMP_ORDERED,
   localparam int        SUM_W     = OFF_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              live,
   input  logic [BASE_W-1:0] wr_base,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [SIZE_W-1:0] wr_size,
   input  logic [BASE_W-1:0] q_base,
   input  logic [OFF_W-1:0]  q_off,
   input  logic [SIZE_W-1:0] q_size,
   output logic              hit
);

   logic [BASE_W-1:0] e_base;
   logic [OFF_W-1:0]  e_off;
   logic [SIZE_W-1:0] e_size;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_base <= '0;
         e_off  <= '0;
         e_size <= '0;
      end else if (wr) begin
         e_base <= wr_base;
         e_off  <= wr_off;
         e_size <= wr_size;
      end
   end

   // Widen both starts by sign and both sizes by zero, then form the ends.
   logic signed [SUM_W-1:0] s_lo, s_hi, l_lo, l_hi;
   assign s_lo = {e_off[OFF_W-1], e_off};
   assign l_lo = {q_off[OFF_W-1], q_off};
   assign s_hi = s_lo + $signed({{(SUM_W - SIZE_W){1'b0}}, e_size});
   assign l_hi = l_lo + $signed({{(SUM_W - SIZE_W){1'b0}}, q_size});

   logic same_base, same_off, range_hit;
   assign same_base = (e_base == q_base);
   assign same_off  = (e_off == q_off);

   if (CMP_STYLE == CMP_ORDERED) begin : g_ordered
      always_comb begin
         if (s_lo < l_lo)
            range_hit = (s_hi > l_lo);
         else
            range_hit = (l_hi > s_lo);
      end
   end else begin : g_span
      assign range_hit = (s_hi > l_lo) && (l_hi > s_lo);
   end

   assign hit = live && same_base && (same_off || range_hit);

   // R5
   base_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live && (q_base != e_base) |-> !hit);

   // R2
   exact_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live && (q_base == e_base) && (q_off == e_off) |-> hit);

   // R2
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (e_base == $past(wr_base)) && (e_off == $past(wr_off)));

endmodule

// File: rtl/stld_alias_table.sv
module stld_alias_table
   import stld_alias_pkg::*;
#(
   parameter int         DEPTH     = 4,
   parameter int         BASE_W    = 8,
   parameter int         OFF_W     = 16,
   parameter int         SIZE_W    = 8,
   parameter cmp_style_e CMP_STYLE = CMP_ORDERED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grp_clr,
   input  logic              st_valid,
   input  logic              st_size_ok,
   input  logic [BASE_W-1:0] st_base,
   input  logic [OFF_W-1:0]  st_off,
   input  logic [SIZE_W-1:0] st_size,
   input  logic              ld_valid,
   input  logic [BASE_W-1:0] ld_base,
   input  logic [OFF_W-1:0]  ld_off,
   input  logic [SIZE_W-1:0] ld_size,
   output logic              ld_hit
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("stld_alias_table: DEPTH must be at least 1");
   end
   if (SIZE_W >= OFF_W) begin : g_bad_size
      $error("stld_alias_table: SIZE_W must be narrower than OFF_W");
   end
   if (BASE_W < 1) begin : g_bad_base
      $error("stld_alias_table: BASE_W must be at least 1");
   end

   logic             push;
   logic [CNT_W-1:0] fill_cnt;
   logic [DEPTH-1:0] wr_en, live, slot_hit;

   assign push = st_valid && st_size_ok;

   stld_fill #(.DEPTH(DEPTH)) u_fill (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (grp_clr),
      .push  (push),
      .cnt   (fill_cnt),
      .wr_en (wr_en),
      .live  (live)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      stld_slot #(
         .BASE_W   (BASE_W),
         .OFF_W    (OFF_W),
         .SIZE_W   (SIZE_W),
         .CMP_STYLE(CMP_STYLE)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (wr_en[i]),
         .live    (live[i]),
         .wr_base (st_base),
         .wr_off  (st_off),
         .wr_size (st_size),
         .q_base  (ld_base),
         .q_off   (ld_off),
         .q_size  (ld_size),
         .hit     (slot_hit[i])
      );
   end

   assign ld_hit = ld_valid && (|slot_hit);

   // R9
   hit_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |-> !ld_hit);

   // R1
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_cnt == '0) |-> !ld_hit);

   // R8
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_clr |=> !ld_hit);

   // R6
   unknown_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid && !st_size_ok && !grp_clr |=> $stable(fill_cnt));

endmodule

// File: tb/stld_alias_table_bench.sv
module stld_alias_table_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        grp_clr = 1'b0;
   logic        st_valid = 1'b0, st_size_ok = 1'b0;
   logic [7:0]  st_base = '0, st_size = '0;
   logic [15:0] st_off = '0;
   logic        ld_valid = 1'b0;
   logic [7:0]  ld_base = '0, ld_size = '0;
   logic [15:0] ld_off = '0;
   logic        ld_hit;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   stld_alias_table u_stld_alias_table (
      .clk(clk), .rst_n(rst_n), .grp_clr(grp_clr),
      .st_valid(st_valid), .st_size_ok(st_size_ok),
      .st_base(st_base), .st_off(st_off), .st_size(st_size),
      .ld_valid(ld_valid), .ld_base(ld_base), .ld_off(ld_off),
      .ld_size(ld_size), .ld_hit(ld_hit)
   );

   typedef struct packed {
      logic [7:0]  sb;
      logic [15:0] so;
      logic [7:0]  ss;
      logic [7:0]  lb;
      logic [15:0] lo;
      logic [7:0]  ls;
      logic        exp;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{8'd1, 16'd100,  8'd4,   8'd1, 16'd100,  8'd4,   1'b1},  // R2 exact
      '{8'd1, 16'd100,  8'd0,   8'd1, 16'd100,  8'd0,   1'b1},  // R2 zero sizes
      '{8'd1, 16'd96,   8'd4,   8'd1, 16'd100,  8'd4,   1'b0},  // R3 touching
      '{8'd1, 16'd96,   8'd5,   8'd1, 16'd100,  8'd1,   1'b1},  // R3 one byte in
      '{8'd1, 16'd104,  8'd4,   8'd1, 16'd100,  8'd4,   1'b0},  // R4 touching
      '{8'd1, 16'd104,  8'd4,   8'd1, 16'd100,  8'd5,   1'b1},  // R4 one byte in
      '{8'd2, 16'd100,  8'd4,   8'd1, 16'd100,  8'd4,   1'b0},  // R5 other base
      '{8'd1, 16'h7FF8, 8'd16,  8'd1, 16'h7FFF, 8'd1,   1'b1},  // R10 no wrap
      '{8'd1, 16'h8000, 8'd4,   8'd1, 16'h8002, 8'd2,   1'b1},  // R10 negative
      '{8'd1, 16'hFFF6, 8'd4,   8'd1, 16'hFFEC, 8'd10,  1'b0},  // R4 negative
      '{8'd1, 16'h7FFF, 8'd255, 8'd1, 16'h8000, 8'd255, 1'b0}   // R10 extremes
   };

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic store(input logic [7:0] b, input logic [15:0] o,
                        input logic [7:0] s, input logic ok);
      @(negedge clk);
      st_valid = 1'b1; st_size_ok = ok; st_base = b; st_off = o; st_size = s;
      @(negedge clk);
      st_valid = 1'b0; st_size_ok = 1'b0;
   endtask

   task automatic probe(input logic [7:0] b, input logic [15:0] o,
                        input logic [7:0] s, output logic h);
      ld_valid = 1'b1; ld_base = b; ld_off = o; ld_size = s;
      #1 h = ld_hit;
      ld_valid = 1'b0;
   endtask

   task automatic clear_all();
      @(negedge clk);
      grp_clr = 1'b1;
      @(negedge clk);
      grp_clr = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic h;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: empty after reset
      probe(8'd0, 16'd0, 8'd4, h);
      check("R1 reset empty", h, 1'b0);

      for (int i = 0; i < NV; i++) begin
         clear_all();
         store(VEC[i].sb, VEC[i].so, VEC[i].ss, 1'b1);
         probe(VEC[i].lb, VEC[i].lo, VEC[i].ls, h);
         check($sformatf("R2/R3/R4/R5/R10 vector %0d", i), h, VEC[i].exp);
      end

      // R6: unknown-size store is not recorded
      clear_all();
      store(8'd3, 16'd20, 8'd4, 1'b0);
      probe(8'd3, 16'd20, 8'd4, h);
      check("R6 unknown size dropped", h, 1'b0);

      // R7: fifth store dropped, first four kept
      clear_all();
      for (int k = 1; k <= 4; k++) store(8'(k), 16'd0, 8'd8, 1'b1);
      store(8'd5, 16'd0, 8'd8, 1'b1);
      probe(8'd5, 16'd0, 8'd8, h);
      check("R7 fifth store dropped", h, 1'b0);
      probe(8'd1, 16'd4, 8'd1, h);
      check("R7 first entry kept", h, 1'b1);
      probe(8'd4, 16'd0, 8'd1, h);
      check("R7 fourth entry kept", h, 1'b1);

      // R8: clear empties the table
      clear_all();
      probe(8'd1, 16'd0, 8'd8, h);
      check("R8 clear empties", h, 1'b0);

      // R8: clear beats a store at the same edge
      @(negedge clk);
      grp_clr = 1'b1; st_valid = 1'b1; st_size_ok = 1'b1;
      st_base = 8'd7; st_off = 16'd40; st_size = 8'd4;
      @(negedge clk);
      grp_clr = 1'b0; st_valid = 1'b0; st_size_ok = 1'b0;
      probe(8'd7, 16'd40, 8'd4, h);
      check("R8 clear wins over store", h, 1'b0);

      // R9: load with ld_valid low never hits
      store(8'd6, 16'd8, 8'd4, 1'b1);
      ld_valid = 1'b0; ld_base = 8'd6; ld_off = 16'd8; ld_size = 8'd4;
      #1 check("R9 no hit without load", ld_hit, 1'b0);

      // R9: same-cycle store is invisible to the load
      clear_all();
      @(negedge clk);
      st_valid = 1'b1; st_size_ok = 1'b1;
      st_base = 8'd9; st_off = 16'd12; st_size = 8'd4;
      probe(8'd9, 16'd12, 8'd4, h);
      check("R9 same-cycle store unseen", h, 1'b0);
      @(negedge clk);
      st_valid = 1'b0; st_size_ok = 1'b0;
      probe(8'd9, 16'd12, 8'd4, h);
      check("R9 store seen next cycle", h, 1'b1);

      finish_run();
   end

endmodule